// File: doc/BRIEF.md
# Row Address Line Driver

This block generates the select pulse for one row of a time-division multiplexed sensor array. It produces a 14-bit code for a DAC that biases the row-select line. Every driver in a system sees the same line-sync and frame-sync strobes and keeps its own copy of the shared row counter. Each driver is given one row index. While the counter equals that index, the driver raises its output from a programmable OFF code to a programmable ON code. The raise comes a programmable number of clock cycles after the line strobe and lasts a programmable number of cycles. At all other times the output rests at the OFF code.

The configuration inputs are copied into a shadow set only on a frame strobe, so software can rewrite them at any time without tearing a frame. A pulse that would run past the end of its line is cut off by the next line strobe, because the row counter moves on at that strobe. Until the first frame strobe arrives the driver is not armed, and it passes the live OFF code through a register.

Top module: `row_addr_driver`

## Requirements
- R1: Once armed, the output carries the ON code only while the internal row counter equals the shadowed row index; a row index the counter never reaches gives no pulse.
- R2: The output is always either the shadowed ON code or the shadowed OFF code once armed, and the two codes are independent 14-bit values.
- R3: On the matching row, with a line strobe sampled at clock edge t and shadowed delay D, the output first shows the ON code after edge t+D+1.
- R4: The ON code is held for exactly the shadowed width W cycles, i.e. after edges t+D+1 through t+D+W, then the OFF code returns.
- R5: A frame strobe sets the row counter to 0 and arms the driver; a line strobe without a frame strobe advances the row counter by one.
- R6: A pulse with D+W longer than the line is truncated: the last ON cycle is the one after the edge of the next line strobe, and from the following edge on the output is OFF.
- R7: Row index, ON code, OFF code, delay and width are copied from the inputs only at an edge where the frame strobe is high; changes at other times have no effect on the output until then.
- R8: From reset until the first frame strobe, the output after each edge equals the OFF code input sampled at that edge (0 while reset is asserted).
- R9: A width of 0 produces no ON cycle on the matching row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_sync | input | 1 | One-cycle strobe at the start of each row period |
| frame_sync | input | 1 | One-cycle strobe marking row 0; also starts a line |
| cfg_row_idx | input | 6 | Row this driver selects |
| cfg_on_level | input | 14 | DAC code while selected |
| cfg_off_level | input | 14 | DAC code while idle |
| cfg_delay | input | 12 | Cycles from line strobe to pulse start |
| cfg_width | input | 12 | Pulse length in cycles |
| dac_code | output | 14 | Code to the row-bias DAC |

## Verification
The driver is run through whole frames at four rows per frame with a pulse placed well inside the line, which checks the row match and the delay and width edges. A second pattern rewrites every setting mid-frame and checks that the old pulse shape and codes persist to the frame end and change at the next strobe. A third sets delay plus width past the line length, which separates correct truncation from a pulse leaking into the next row. Further patterns cover a zero width, a row index the counter never reaches, and line strobes before any frame strobe, where the output must follow the live OFF code.

// File: rtl/rowdrv_pkg.sv
package rowdrv_pkg;
    localparam int ROW_W = 6;
    localparam int DAC_W = 14;
    localparam int PH_W  = 12;
    localparam int WIN_W = PH_W + 1;

    typedef struct packed {
        logic [ROW_W-1:0] row_idx;
        logic [DAC_W-1:0] on_lvl;
        logic [DAC_W-1:0] off_lvl;
        logic [PH_W-1:0]  delay;
        logic [PH_W-1:0]  width;
    } drv_cfg_t;
endpackage

// File: rtl/rowdrv_sequencer.sv
module rowdrv_sequencer
    import rowdrv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             frame_start,
    output logic [ROW_W-1:0] row_q,
    output logic             armed_q
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             armed;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_start) begin
            s_d.row   = '0;
            s_d.armed = 1'b1;
        end else if (line_start) begin
            s_d.row = s_q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_q   = s_q.row;
    assign armed_q = s_q.armed;

    // R5: frame strobe restarts the count and arms
    a_r5_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (row_q == '0) && armed_q);

    // R5: a bare line strobe advances by one
    a_r5_line_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !frame_start) |=> (row_q == ROW_W'($past(row_q) + 1'b1)));
endmodule

// File: rtl/rowdrv_shadow.sv
module rowdrv_shadow
    import rowdrv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_start,
    input  drv_cfg_t cfg_in,
    output drv_cfg_t cfg_q
);
    drv_cfg_t cfg_d, cfg_r;

    always_comb begin
        cfg_d = cfg_r;
        if (frame_start) cfg_d = cfg_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_r <= '0;
        else        cfg_r <= cfg_d;
    end

    assign cfg_q = cfg_r;

    // R7: shadow copy only moves on a frame strobe
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(cfg_q));
endmodule

// File: rtl/rowdrv_phase.sv
module rowdrv_phase
    import rowdrv_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_start,
    output logic [PH_W-1:0] phase_q
);
    localparam logic [PH_W-1:0] PH_MAX = '1;

    logic [PH_W-1:0] ph_d, ph_r;

    always_comb begin
        ph_d = ph_r;
        if (line_start)         ph_d = '0;
        else if (ph_r != PH_MAX) ph_d = ph_r + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_r <= PH_MAX;
        else        ph_r <= ph_d;
    end

    assign phase_q = ph_r;

    // R3: phase restarts at every line strobe
    a_r3_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (phase_q == '0));

    // R4: phase never wraps back toward zero without a strobe
    a_r4_phase_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> (phase_q >= $past(phase_q)));
endmodule

// File: rtl/row_addr_driver.sv
module row_addr_driver
    import rowdrv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic [ROW_W-1:0] cfg_row_idx,
    input  logic [DAC_W-1:0] cfg_on_level,
    input  logic [DAC_W-1:0] cfg_off_level,
    input  logic [PH_W-1:0]  cfg_delay,
    input  logic [PH_W-1:0]  cfg_width,
    output logic [DAC_W-1:0] dac_code
);
    logic             line_start;
    logic [ROW_W-1:0] row_q;
    logic             armed_q;
    logic [PH_W-1:0]  phase_q;
    drv_cfg_t         cfg_live, cfg_sh;

    assign line_start = line_sync | frame_sync;

    always_comb begin
        cfg_live.row_idx = cfg_row_idx;
        cfg_live.on_lvl  = cfg_on_level;
        cfg_live.off_lvl = cfg_off_level;
        cfg_live.delay   = cfg_delay;
        cfg_live.width   = cfg_width;
    end

    rowdrv_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .frame_start(frame_sync),
        .row_q      (row_q),
        .armed_q    (armed_q)
    );

    rowdrv_shadow u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_sync),
        .cfg_in     (cfg_live),
        .cfg_q      (cfg_sh)
    );

    rowdrv_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .phase_q   (phase_q)
    );

    typedef struct packed {
        logic [DAC_W-1:0] dac;
    } out_t;

    out_t o_d, o_q;
    logic [WIN_W-1:0] win_end;
    logic             in_window;
    logic             row_hit;

    always_comb begin
        win_end   = WIN_W'(cfg_sh.delay) + WIN_W'(cfg_sh.width);
        row_hit   = (row_q == cfg_sh.row_idx);
        in_window = (WIN_W'(phase_q) >= WIN_W'(cfg_sh.delay)) &&
                    (WIN_W'(phase_q) <  win_end);
        o_d = o_q;
        if (!armed_q)               o_d.dac = cfg_off_level;
        else if (row_hit && in_window) o_d.dac = cfg_sh.on_lvl;
        else                        o_d.dac = cfg_sh.off_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign dac_code = o_q.dac;

    // R8: before arming the output follows the live OFF code
    a_r8_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |=> (dac_code == $past(cfg_off_level)));

    // R2: once armed only the two shadowed codes appear
    a_r2_two_levels: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |=> ((dac_code == $past(cfg_sh.on_lvl)) ||
                     (dac_code == $past(cfg_sh.off_lvl))));

    // R1: a non-matching row yields OFF
    a_r1_row_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && (row_q != cfg_sh.row_idx)) |=> (dac_code == $past(cfg_sh.off_lvl)));
endmodule

// File: tb/tb_row_addr_driver.sv
module tb_row_addr_driver;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS      = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_sync = 1'b0;
    logic        frame_sync = 1'b0;
    logic [5:0]  cfg_row_idx = '0;
    logic [13:0] cfg_on_level = '0;
    logic [13:0] cfg_off_level = '0;
    logic [11:0] cfg_delay = '0;
    logic [11:0] cfg_width = '0;
    logic [13:0] dac_code;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R8";
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    row_addr_driver dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_sync    (line_sync),
        .frame_sync   (frame_sync),
        .cfg_row_idx  (cfg_row_idx),
        .cfg_on_level (cfg_on_level),
        .cfg_off_level(cfg_off_level),
        .cfg_delay    (cfg_delay),
        .cfg_width    (cfg_width),
        .dac_code     (dac_code)
    );

    // Reference state built from the requirements
    int          m_row = 0;
    bit          m_armed = 1'b0;
    int          m_ph = 4095;
    int          s_row = 0, s_dly = 0, s_wid = 0;
    logic [13:0] s_on = '0, s_off = '0;
    logic [13:0] exp_q[$];

    // driver side: push the value expected after this edge
    always @(posedge clk) begin
        logic [13:0] e;
        if (!rst_n) begin
            e = '0;
            m_row = 0; m_armed = 1'b0; m_ph = 4095;
            s_row = 0; s_dly = 0; s_wid = 0; s_on = '0; s_off = '0;
        end else begin
            if (!m_armed) e = cfg_off_level;
            else if (m_row == s_row && m_ph >= s_dly && m_ph < s_dly + s_wid) e = s_on;
            else e = s_off;
            if (frame_sync) begin
                m_row = 0; m_armed = 1'b1;
                s_row = cfg_row_idx; s_on = cfg_on_level; s_off = cfg_off_level;
                s_dly = cfg_delay; s_wid = cfg_width;
            end else if (line_sync) begin
                m_row = (m_row + 1) % 64;
            end
            if (line_sync || frame_sync) m_ph = 0;
            else if (m_ph < 4095) m_ph = m_ph + 1;
        end
        exp_q.push_back(e);
    end

    // monitor: pop and compare away from the edge
    int on_seen = 0;
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [13:0] e;
            e = exp_q.pop_front();
            n_cmp++;
            if (dac_code != e) begin
                n_bad++;
                $display("FAIL %s: dac_code actual %h expected %h at %0t", tag, dac_code, e, $time);
            end
        end
    end

    task automatic one_line(input bit frm, input int len);
        line_sync  = 1'b1;
        frame_sync = frm;
        @(negedge clk);
        line_sync  = 1'b0;
        frame_sync = 1'b0;
        repeat (len - 1) @(negedge clk);
    endtask

    task automatic one_frame(input int len);
        for (int r = 0; r < NROWS; r++) one_line(r == 0, len);
    endtask

    task automatic direct_check(input string t, input logic [13:0] exp);
        n_cmp++;
        if (dac_code != exp) begin
            n_bad++;
            $display("FAIL %s: dac_code actual %h expected %h", t, dac_code, exp);
        end
    endtask

    initial begin
        cfg_off_level = 14'h0155;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        direct_check("R8 reset", 14'h0155);

        // R8: line strobes before any frame strobe, live OFF changes pass through
        tag = "R8";
        cfg_row_idx = 6'd0; cfg_on_level = 14'h2AAA; cfg_delay = 12'd0; cfg_width = 12'd5;
        one_line(1'b0, 12);
        cfg_off_level = 14'h0777;
        one_line(1'b0, 12);
        direct_check("R8 live", 14'h0777);

        // R1 R2 R3 R4 R5: pulse well inside the line on row 2
        tag = "R1 R2 R3 R4 R5";
        cfg_row_idx = 6'd2; cfg_on_level = 14'h2AAA; cfg_off_level = 14'h0155;
        cfg_delay = 12'd3; cfg_width = 12'd4;
        one_frame(12);
        one_frame(12);

        // R7: rewrite every setting just after the frame strobe
        tag = "R7";
        one_line(1'b1, 12);
        cfg_row_idx = 6'd1; cfg_on_level = 14'h3C3C; cfg_off_level = 14'h0011;
        cfg_delay = 12'd1; cfg_width = 12'd2;
        for (int r = 1; r < NROWS; r++) one_line(1'b0, 12);
        one_frame(12);

        // R6: delay plus width beyond the line length
        tag = "R6";
        cfg_row_idx = 6'd1; cfg_delay = 12'd8; cfg_width = 12'd20;
        one_frame(12);
        one_frame(12);

        // R9: zero width
        tag = "R9";
        cfg_delay = 12'd2; cfg_width = 12'd0;
        one_frame(12);
        one_frame(12);

        // R1: index the counter never reaches
        tag = "R1";
        cfg_row_idx = 6'd5; cfg_delay = 12'd0; cfg_width = 12'd10;
        one_frame(12);
        one_frame(16);

        // R3 R4: zero delay, different line length
        tag = "R3 R4";
        cfg_row_idx = 6'd3; cfg_delay = 12'd0; cfg_width = 12'd3;
        one_frame(16);
        one_frame(16);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule